// File: doc/BRIEF.md
# Single-Bus Arithmetic Logic Unit with Operand Latch

This unit serves a processor whose datapath shares one bus, which carries a single value per cycle. Operands reach the unit over that bus in separate cycles. Each load pulse captures the bus value into one of two internal operand registers. The first load after a result write fills operand A, and the second fills operand B. Every function of the latched operands is formed at the same time: add, subtract, AND, OR, NOT and increment. A one-hot group of write strobes picks the result that goes back onto the bus.

The control unit advances the program counter with the increment path. It drives the counter onto the bus and pulses load. In the very next cycle it raises the increment strobe, and the bus carries A+1. Whenever a result is written to the bus, the unit also captures negative and zero status flags. The control unit reads these flags to decide conditional jumps.

Top module: `sbus_alu`

## Requirements
- R1: After reset, both operands are zero, the next load fills operand A, both flags are 0, bus_drive is 0 and bus_out is zero.
- R2: The first `ld` pulse after reset, or after any cycle with a write strobe, captures `bus_in` into A. The next pulse captures into B, and any further pulses before a write overwrite B again. When `ld` and a strobe occur in the same cycle, the load uses the current slot and the slot then returns to A.
- R3: With only `wr_op[0]` set, `bus_out` is (A + B) modulo 2^W in the same cycle.
- R4: With only `wr_op[1]` set, `bus_out` is A - B in two's complement, modulo 2^W.
- R5: With only `wr_op[2]` set, `bus_out` is A AND B. With only `wr_op[3]` set, `bus_out` is A OR B.
- R6: With only `wr_op[4]` set, `bus_out` is NOT A. B has no effect on the result.
- R7: With only `wr_op[5]` set, `bus_out` is A + 1 modulo 2^W. This result is correct in the cycle right after A was loaded.
- R8: When no strobe is set, `bus_drive` is 0 and `bus_out` is zero.
- R9: When several strobes are set at once, the lowest-numbered set bit of `wr_op` selects the result, and `bus_drive` is 1.
- R10: At the clock edge that ends a write cycle, `flag_neg` takes the most significant bit of the driven result, and `flag_zero` is set exactly when all bits of that result are zero. The flags keep their values in cycles without a write, including load cycles.
- R11: A write leaves both operands unchanged. Repeating a strobe therefore gives the same result again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | W | Value currently on the shared bus |
| ld | input | 1 | Load pulse: capture bus_in into the current operand slot |
| wr_op | input | 6 | Write strobes: 0 add, 1 subtract, 2 AND, 3 OR, 4 NOT, 5 increment |
| bus_out | output | W | Selected result, zero when no strobe is set |
| bus_drive | output | 1 | High while the unit drives the bus |
| flag_neg | output | 1 | Sign bit of the last written result |
| flag_zero | output | 1 | Last written result was zero |

## Verification
Operand pairs are chosen so that each function gives a distinct value; a wrong selection in the mux therefore shows up as a wrong number. Two-operand tests load A and B in swapped order, which exposes operand swaps in subtraction. A subtraction that crosses zero and an increment from 0x7F and from 0xFF exercise both flags and modulo wraparound. Three loads in a row, idle cycles between loads and writes, repeated strobes and several strobes at once check slot sequencing, flag holding, operand retention and priority.

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         ld,
  input  logic [5:0]   wr_op,
  output logic [W-1:0] bus_out,
  output logic         bus_drive,
  output logic         flag_neg,
  output logic         flag_zero
);

  logic [W-1:0] a_q, b_q;
  logic         slot_b;

  wire [W-1:0] r_add = a_q + b_q;
  wire [W-1:0] r_sub = a_q - b_q;
  wire [W-1:0] r_and = a_q & b_q;
  wire [W-1:0] r_or  = a_q | b_q;
  wire [W-1:0] r_not = ~a_q;
  wire [W-1:0] r_inc = a_q + W'(1);

  logic [W-1:0] sel;
  always_comb begin
    if      (wr_op[0]) sel = r_add;
    else if (wr_op[1]) sel = r_sub;
    else if (wr_op[2]) sel = r_and;
    else if (wr_op[3]) sel = r_or;
    else if (wr_op[4]) sel = r_not;
    else if (wr_op[5]) sel = r_inc;
    else               sel = '0;
  end

  assign bus_drive = |wr_op;
  assign bus_out   = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q       <= '0;
      b_q       <= '0;
      slot_b    <= 1'b0;
      flag_neg  <= 1'b0;
      flag_zero <= 1'b0;
    end else begin
      if (ld) begin
        if (slot_b) b_q <= bus_in;
        else        a_q <= bus_in;
      end
      if (bus_drive) begin
        slot_b    <= 1'b0;
        flag_neg  <= sel[W-1];
        flag_zero <= (sel == '0);
      end else if (ld) begin
        slot_b    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbus_alu_chk.sv
module sbus_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_in,
  input logic         ld,
  input logic [5:0]   wr_op,
  input logic [W-1:0] bus_out,
  input logic         bus_drive,
  input logic         flag_neg,
  input logic         flag_zero,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic         slot_b
);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == 6'b0) |-> (bus_out == '0 && !bus_drive));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == 6'b0) |=> ($stable(flag_neg) && $stable(flag_zero)));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op != 6'b0) |=> (flag_zero == ($past(bus_out) == '0)));

  p_neg_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op != 6'b0) |=> (flag_neg == $past(bus_out[W-1])));

  p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !slot_b) |=> (a_q == $past(bus_in)));

  p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == 6'b100000) |-> (bus_out == a_q + W'(1)));

  p_write_keeps_ops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op != 6'b0 && !ld) |=> ($stable(a_q) && $stable(b_q)));

endmodule

bind sbus_alu sbus_alu_chk #(.W(W)) u_chk (.*);

// File: tb/test_sbus_alu.sv
module test_sbus_alu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic         ld = 1'b0;
  logic [5:0]   wr_op = '0;
  logic [W-1:0] bus_out;
  logic         bus_drive;
  logic         flag_neg, flag_zero;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int ma = 0, mb = 0, mslot = 0, mneg = 0, mzero = 0;

  always #4 clk = ~clk;

  sbus_alu #(.W(W)) i_sbus_alu (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld(ld), .wr_op(wr_op),
    .bus_out(bus_out), .bus_drive(bus_drive),
    .flag_neg(flag_neg), .flag_zero(flag_zero)
  );

  function automatic int model_out(input logic [5:0] op);
    int m = (1 << W) - 1;
    if (op[0]) return (ma + mb) & m;
    if (op[1]) return (ma - mb) & m;
    if (op[2]) return ma & mb;
    if (op[3]) return ma | mb;
    if (op[4]) return (~ma) & m;
    if (op[5]) return (ma + 1) & m;
    return 0;
  endfunction

  task automatic step(input logic l, input int v, input logic [5:0] op, input string tag);
    int eo;
    int ed;
    @(negedge clk);
    ld = l; bus_in = W'(v); wr_op = op;
    #2;
    eo = model_out(op);
    ed = (op != 0) ? 1 : 0;
    checks++;
    if (int'(bus_out) != eo || int'(bus_drive) != ed) begin
      failures++;
      $display("FAIL %s bus: actual out=%0h drive=%0b expected out=%0h drive=%0b",
               tag, bus_out, bus_drive, eo, ed);
    end
    checks++;
    if (int'(flag_neg) != mneg || int'(flag_zero) != mzero) begin
      failures++;
      $display("FAIL %s flags: actual neg=%0b zero=%0b expected neg=%0b zero=%0b",
               tag, flag_neg, flag_zero, mneg, mzero);
    end
    @(posedge clk);
    if (l) begin
      if (mslot == 1) mb = v & ((1 << W) - 1);
      else            ma = v & ((1 << W) - 1);
    end
    if (op != 0) begin
      mneg = (eo >> (W - 1)) & 1;
      mzero = (eo == 0) ? 1 : 0;
      mslot = 0;
    end else if (l) begin
      mslot = 1;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 6'b000000, "R1");
    step(0, 0, 6'b000000, "R8");
    step(1, 5, 6'b000000, "R2");
    step(1, 3, 6'b000000, "R2");
    step(0, 0, 6'b000001, "R3");
    step(1, 3, 6'b000000, "R2");
    step(1, 5, 6'b000000, "R2");
    step(0, 0, 6'b000010, "R4");
    step(0, 0, 6'b000000, "R10");
    step(0, 0, 6'b000010, "R11");
    step(1, 8'hF0, 6'b000000, "R2");
    step(1, 8'h3C, 6'b000000, "R2");
    step(0, 0, 6'b000100, "R5");
    step(0, 0, 6'b001000, "R5");
    step(1, 8'hFF, 6'b000000, "R2");
    step(1, 8'h12, 6'b000000, "R10");
    step(0, 0, 6'b010000, "R6");
    step(1, 8'h7F, 6'b000000, "R2");
    step(0, 0, 6'b100000, "R7");
    step(1, 8'hFF, 6'b000000, "R2");
    step(0, 0, 6'b100000, "R7");
    step(1, 1, 6'b000000, "R2");
    step(1, 2, 6'b000000, "R2");
    step(1, 9, 6'b000000, "R2");
    step(0, 0, 6'b000000, "R8");
    step(0, 0, 6'b000001, "R3");
    step(0, 0, 6'b100001, "R9");
    step(0, 0, 6'b110100, "R9");
    step(1, 8'h40, 6'b011000, "R2");
    step(0, 0, 6'b100000, "R7");
    step(0, 0, 6'b000000, "R10");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule